// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block holds the operating-mode state of a bus transceiver's digital core. It follows five modes: Normal, Receive-only, Standby, Go-to-sleep and Sleep. Two mode-select pins normally choose the mode. Three latched supply-undervoltage flags, covering battery, I/O and core, can override that choice, and so can a wake event. Supply sensing is outside the block, which sees set and clear strobes for each undervoltage flag and a one-cycle wake strobe.

The block also chooses the symbol that the analog driver puts on the bus. It gates the transmit data with the bus-guardian enable and the active-low transmit enable. It refuses to open a transmission on a high data bit, and it only lets a transmission run when the enable was raised while in Normal mode. A transmit enable held too long is cut off by a timeout. A separate output keeps an external regulator switched on in every mode except Sleep.

Every output is registered. Inputs sampled at a rising edge show on the outputs right after that edge.

Top module: `trx_mode_ctrl`

## Requirements
- R1: While the synchronous reset is high, mode_o is Standby (2), bus_sym_o is Idle_LP (0), uv_flags_o is 0, txen_tmo_o is 0 and inh_oe_o is 1.
- R2: With no flag forcing a mode, the pins {stbn_i,en_i} select the mode. 11 gives Normal (0), 10 gives Receive-only (1), 00 gives Standby (2) and 01 gives Go-to-sleep (3).
- R3: Go-to-sleep becomes Sleep (4) after GTS_HOLD cycles. Once in Sleep, the block stays there while stbn_i is low, whatever en_i is.
- R4: When the battery flag (uv_flags_o bit 0) or the I/O flag (bit 1) is set, mode_o is Sleep.
- R5: When only the core flag (bit 2) is set, mode_o is Standby, unless the block was already in Sleep, in which case it stays in Sleep.
- R6: A flag is set by its uv_set_i bit and held until its uv_clr_i bit (set wins if both arrive together). Once all flags are clear, the pins decide the mode again.
- R7: A wake_i pulse clears all undervoltage flags and moves the block to Standby on that same edge.
- R8: bus_sym_o is encoded 0=Idle_LP, 1=Idle, 2=Data_0, 3=Data_1. In Standby, Go-to-sleep and Sleep it is Idle_LP. In Receive-only it is Idle. In Normal it is Idle unless a transmission is running and bge_i is 1, in which case txd_i selects Data_0 (0) or Data_1 (1).
- R9: A transmission starts only on a cycle where txen_n_i is low and txd_i is 0. While txd_i stays 1 after txen_n_i falls, the bus stays Idle.
- R10: A transmission can only start if txen_n_i went low while in Normal. Leaving Normal ends a transmission, and a new one needs txen_n_i to go high and low again in Normal.
- R11: After TX_TMO_CYCLES consecutive sampled cycles with txen_n_i low, txen_tmo_o rises and the bus returns to Idle on that edge. Both stay that way until txen_n_i goes high, which clears txen_tmo_o.
- R12: inh_oe_o is 1 in every mode except Sleep, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stbn_i | input | 1 | Mode-select pin, active-low standby |
| en_i | input | 1 | Mode-select pin, enable |
| uv_set_i | input | 3 | Undervoltage set strobes: bit0 battery, bit1 I/O, bit2 core |
| uv_clr_i | input | 3 | Undervoltage recovery strobes, same bit order |
| wake_i | input | 1 | Wake event strobe |
| bge_i | input | 1 | Bus-guardian transmit enable |
| txen_n_i | input | 1 | Transmit enable, active low |
| txd_i | input | 1 | Transmit data |
| mode_o | output | 3 | Current mode code |
| bus_sym_o | output | 2 | Encoded bus symbol |
| txen_tmo_o | output | 1 | Transmit-enable timeout flag |
| inh_oe_o | output | 1 | Regulator-inhibit drive enable |
| uv_flags_o | output | 3 | Latched undervoltage flags |

## Verification
The bench drops the transmit enable while txd_i is high. A design that let a session open on a high bit would put Data_1 on the bus at once. It lowers the enable in Receive-only and then switches to Normal. A design that armed the transmitter from the enable level alone would send Data_0 there. It holds the enable past the timeout and expects Idle on exactly the edge where the flag rises. An off-by-one counter shows up as one extra data symbol or one missing one. Finally, it clears the battery flag while the core flag is still set in Sleep, where a design that obeyed the core rule blindly would climb to Standby, and it checks that wake wipes every flag.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;

  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_RXONLY = 3'd1,
    MD_STBY   = 3'd2,
    MD_GTS    = 3'd3,
    MD_SLEEP  = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    SYM_IDLE_LP = 2'd0,
    SYM_IDLE    = 2'd1,
    SYM_DATA0   = 2'd2,
    SYM_DATA1   = 2'd3
  } sym_e;

  localparam int UV_BAT  = 0;
  localparam int UV_IO   = 1;
  localparam int UV_CORE = 2;
  localparam int UV_W    = 3;

endpackage

// File: rtl/trx_uv_flags.sv
module trx_uv_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         wake_i,
  output logic [N-1:0] flags_n_o,
  output logic [N-1:0] flags_q_o
);

  logic [N-1:0] flags_q;

  // one latch per supply; wake wipes all, set beats a concurrent clear
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (wake_i) flags_n_o[i] = 1'b0;
      else        flags_n_o[i] = (flags_q[i] & ~clr_i[i]) | set_i[i];
    end

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_n_o[i];
    end
  end

  assign flags_q_o = flags_q;

endmodule

// File: rtl/trx_mode_fsm.sv
module trx_mode_fsm
  import trx_mode_pkg::*;
#(
  parameter int GTS_HOLD = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  stbn_i,
  input  logic  en_i,
  input  logic  wake_i,
  input  logic  force_sleep_i,
  input  logic  force_stby_i,
  output mode_e mode_n_o,
  output mode_e mode_q_o
);

  localparam int GW = $clog2(GTS_HOLD + 1);
  localparam logic [GW-1:0] DWELL_LAST = GW'(GTS_HOLD - 1);

  mode_e           mode_q;
  mode_e           pin_mode;
  logic [GW-1:0]   dwell_q, dwell_n;
  logic            dwell_done;

  always_comb begin
    unique case ({stbn_i, en_i})
      2'b11:   pin_mode = MD_NORMAL;
      2'b10:   pin_mode = MD_RXONLY;
      2'b01:   pin_mode = MD_GTS;
      default: pin_mode = MD_STBY;
    endcase

    dwell_done = (mode_q == MD_GTS) && (dwell_q == DWELL_LAST);

    if (wake_i)                              mode_n_o = MD_STBY;
    else if (force_sleep_i)                  mode_n_o = MD_SLEEP;
    else if (force_stby_i)                   mode_n_o = (mode_q == MD_SLEEP) ? MD_SLEEP : MD_STBY;
    else if (mode_q == MD_SLEEP && !stbn_i)  mode_n_o = MD_SLEEP;
    else if (pin_mode == MD_GTS && dwell_done) mode_n_o = MD_SLEEP;
    else                                     mode_n_o = pin_mode;

    if (mode_q == MD_GTS && mode_n_o == MD_GTS) dwell_n = dwell_q + GW'(1);
    else                                        dwell_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_STBY;
      dwell_q <= '0;
    end else begin
      mode_q  <= mode_n_o;
      dwell_q <= dwell_n;
    end
  end

  assign mode_q_o = mode_q;

endmodule

// File: rtl/trx_tx_path.sv
module trx_tx_path
  import trx_mode_pkg::*;
#(
  parameter int TMO_CYCLES = 1000
) (
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_n_i,
  input  logic  bge_i,
  input  logic  txen_n_i,
  input  logic  txd_i,
  output sym_e  sym_o,
  output logic  tmo_o
);

  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(TMO_CYCLES);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tmo_q, tmo_n;
  logic          armed_q, armed_n;
  logic          active_q, active_n;
  logic          in_normal;
  sym_e          sym_q, sym_n;

  always_comb begin
    in_normal = (mode_n_i == MD_NORMAL);

    if (txen_n_i)          cnt_n = '0;
    else if (cnt_q == CMAX) cnt_n = CMAX;
    else                   cnt_n = cnt_q + CW'(1);
    tmo_n = (cnt_n == CMAX);

    // armed remembers whether the enable went low while in Normal
    if (txen_n_i) armed_n = in_normal;
    else          armed_n = armed_q && in_normal && !tmo_n;

    active_n = !txen_n_i && !tmo_n && in_normal &&
               (active_q || (armed_q && !txd_i));

    if (in_normal) begin
      if (bge_i && active_n) sym_n = txd_i ? SYM_DATA1 : SYM_DATA0;
      else                   sym_n = SYM_IDLE;
    end else if (mode_n_i == MD_RXONLY) begin
      sym_n = SYM_IDLE;
    end else begin
      sym_n = SYM_IDLE_LP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      tmo_q    <= 1'b0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      sym_q    <= SYM_IDLE_LP;
    end else begin
      cnt_q    <= cnt_n;
      tmo_q    <= tmo_n;
      armed_q  <= armed_n;
      active_q <= active_n;
      sym_q    <= sym_n;
    end
  end

  assign sym_o = sym_q;
  assign tmo_o = tmo_q;

endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
  import trx_mode_pkg::*;
#(
  parameter int GTS_HOLD      = 64,
  parameter int TX_TMO_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stbn_i,
  input  logic            en_i,
  input  logic [UV_W-1:0] uv_set_i,
  input  logic [UV_W-1:0] uv_clr_i,
  input  logic            wake_i,
  input  logic            bge_i,
  input  logic            txen_n_i,
  input  logic            txd_i,
  output logic [2:0]      mode_o,
  output logic [1:0]      bus_sym_o,
  output logic            txen_tmo_o,
  output logic            inh_oe_o,
  output logic [UV_W-1:0] uv_flags_o
);

  logic [UV_W-1:0] flags_n, flags_q;
  mode_e           mode_n, mode_q;
  sym_e            sym;
  logic            inh_q;

  trx_uv_flags #(.N(UV_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (uv_set_i),
    .clr_i    (uv_clr_i),
    .wake_i   (wake_i),
    .flags_n_o(flags_n),
    .flags_q_o(flags_q)
  );

  trx_mode_fsm #(.GTS_HOLD(GTS_HOLD)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .stbn_i       (stbn_i),
    .en_i         (en_i),
    .wake_i       (wake_i),
    .force_sleep_i(flags_n[UV_BAT] | flags_n[UV_IO]),
    .force_stby_i (flags_n[UV_CORE]),
    .mode_n_o     (mode_n),
    .mode_q_o     (mode_q)
  );

  trx_tx_path #(.TMO_CYCLES(TX_TMO_CYCLES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .mode_n_i(mode_n),
    .bge_i   (bge_i),
    .txen_n_i(txen_n_i),
    .txd_i   (txd_i),
    .sym_o   (sym),
    .tmo_o   (txen_tmo_o)
  );

  always_ff @(posedge clk) begin
    if (rst) inh_q <= 1'b1;
    else     inh_q <= (mode_n != MD_SLEEP);
  end

  assign mode_o     = mode_q;
  assign bus_sym_o  = sym;
  assign inh_oe_o   = inh_q;
  assign uv_flags_o = flags_q;

endmodule

// File: rtl/trx_mode_ctrl_chk.sv
module trx_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wake_i,
  input logic [2:0] mode_o,
  input logic [1:0] bus_sym_o,
  input logic       txen_tmo_o,
  input logic       inh_oe_o,
  input logic [2:0] uv_flags_o
);

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd4);

  p_uv_sleep_r4: assert property (@(posedge clk) disable iff (rst)
    (uv_flags_o[0] || uv_flags_o[1]) |-> mode_o == 3'd4);

  p_core_stby_r5: assert property (@(posedge clk) disable iff (rst)
    uv_flags_o[2] |-> (mode_o == 3'd2 || mode_o == 3'd4));

  p_wake_stby_r7: assert property (@(posedge clk) disable iff (rst)
    wake_i |=> (mode_o == 3'd2 && uv_flags_o == 3'd0));

  p_lowpwr_sym_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o >= 3'd2) |-> bus_sym_o == 2'd0);

  p_data_in_normal_r8: assert property (@(posedge clk) disable iff (rst)
    bus_sym_o[1] |-> mode_o == 3'd0);

  p_tmo_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    txen_tmo_o |-> !bus_sym_o[1]);

  p_inh_r12: assert property (@(posedge clk) disable iff (rst)
    inh_oe_o == (mode_o != 3'd4));

endmodule

bind trx_mode_ctrl trx_mode_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wake_i    (wake_i),
  .mode_o    (mode_o),
  .bus_sym_o (bus_sym_o),
  .txen_tmo_o(txen_tmo_o),
  .inh_oe_o  (inh_oe_o),
  .uv_flags_o(uv_flags_o)
);

// File: tb/trx_mode_ctrl_bench.sv
`timescale 1ns/1ps
module trx_mode_ctrl_bench;

  localparam int GTS_H = 4;
  localparam int TMO   = 8;
  localparam logic [2:0] M_NRM = 3'd0, M_RXO = 3'd1, M_SBY = 3'd2, M_GTS = 3'd3, M_SLP = 3'd4;
  localparam logic [1:0] S_LP = 2'd0, S_ID = 2'd1, S_D0 = 2'd2, S_D1 = 2'd3;

  typedef struct {
    bit         chk;
    logic [2:0] m;
    logic [1:0] s;
    logic       t;
    logic [2:0] f;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stbn = 1'b0, en = 1'b0, wake = 1'b0, bge = 1'b1, txen_n = 1'b1, txd = 1'b0;
  logic [2:0] uv_set = 3'd0, uv_clr = 3'd0;
  logic [2:0] mode;
  logic [1:0] sym;
  logic       tmo, inh;
  logic [2:0] flags;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  trx_mode_ctrl #(.GTS_HOLD(GTS_H), .TX_TMO_CYCLES(TMO)) u_trx_mode_ctrl (
    .clk(clk), .rst(rst), .stbn_i(stbn), .en_i(en), .uv_set_i(uv_set), .uv_clr_i(uv_clr),
    .wake_i(wake), .bge_i(bge), .txen_n_i(txen_n), .txd_i(txd),
    .mode_o(mode), .bus_sym_o(sym), .txen_tmo_o(tmo), .inh_oe_o(inh), .uv_flags_o(flags)
  );

  // driver: inputs are already set; push the expectation, move to next negedge
  task automatic cyc(input bit chk, input logic [2:0] m, input logic [1:0] s,
                     input logic t, input logic [2:0] f, input string tag);
    exp_t e;
    e.chk = chk; e.m = m; e.s = s; e.t = t; e.f = f; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    uv_set = 3'd0; uv_clr = 3'd0; wake = 1'b0;
  endtask

  // monitor: compares just after each rising edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.chk) begin
        total++;
        if (mode !== e.m || sym !== e.s || tmo !== e.t || flags !== e.f || inh !== (e.m != M_SLP)) begin
          bad++;
          $display("FAIL %s: got mode=%0d sym=%0d tmo=%0d flags=%b inh=%0d exp mode=%0d sym=%0d tmo=%0d flags=%b inh=%0d",
                   e.tag, mode, sym, tmo, flags, inh, e.m, e.s, e.t, e.f, (e.m != M_SLP));
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R1 reset state");
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R1 reset state held");
    rst = 1'b0;
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R2 pins 00 standby");

    // Normal and transmit
    stbn = 1; en = 1;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R2 pins 11 normal");
    txen_n = 0; txd = 1;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R9 no start on data_1");
    txd = 0;
    cyc(1, M_NRM, S_D0, 0, 3'd0, "R9 start on data_0");
    txd = 1;
    cyc(1, M_NRM, S_D1, 0, 3'd0, "R8 data_1 sent");
    bge = 0;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R8 guardian blocks");
    bge = 1; txd = 0;
    cyc(1, M_NRM, S_D0, 0, 3'd0, "R8 guardian released");
    txd = 1;
    cyc(1, M_NRM, S_D1, 0, 3'd0, "R11 before limit");
    cyc(1, M_NRM, S_D1, 0, 3'd0, "R11 last data cycle");
    cyc(1, M_NRM, S_ID, 1, 3'd0, "R11 timeout fires");
    txd = 0;
    cyc(1, M_NRM, S_ID, 1, 3'd0, "R11 timeout holds");
    txen_n = 1;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R11 timeout clears");
    txen_n = 0;
    cyc(1, M_NRM, S_D0, 0, 3'd0, "R10 restart in normal");
    txen_n = 1;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R8 idle after frame");

    // Receive-only, enable lowered outside Normal
    en = 0;
    cyc(1, M_RXO, S_ID, 0, 3'd0, "R2 pins 10 receive-only");
    txen_n = 0; txd = 0;
    cyc(1, M_RXO, S_ID, 0, 3'd0, "R8 receive-only ignores tx");
    en = 1;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R10 enable began outside normal");
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R10 still blocked");
    txen_n = 1;
    cyc(0, M_NRM, S_ID, 0, 3'd0, "");
    txen_n = 0;
    cyc(1, M_NRM, S_D0, 0, 3'd0, "R10 re-armed in normal");
    txen_n = 1;
    cyc(0, M_NRM, S_ID, 0, 3'd0, "");

    // Low-power modes
    stbn = 0; en = 0; txen_n = 0; txd = 0;
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R8 standby idle_lp");
    txen_n = 1; en = 1;
    cyc(1, M_GTS, S_LP, 0, 3'd0, "R2 pins 01 go-to-sleep");
    cyc(1, M_GTS, S_LP, 0, 3'd0, "R3 dwell 1");
    cyc(1, M_GTS, S_LP, 0, 3'd0, "R3 dwell 2");
    cyc(1, M_GTS, S_LP, 0, 3'd0, "R3 dwell 3");
    cyc(1, M_SLP, S_LP, 0, 3'd0, "R3 sleep after dwell R12");
    en = 0;
    cyc(1, M_SLP, S_LP, 0, 3'd0, "R3 sleep held stbn low");
    wake = 1;
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R7 wake to standby");
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R2 standby after wake");

    // Undervoltage
    stbn = 1; en = 1;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R2 back to normal");
    uv_set = 3'b100;
    cyc(1, M_SBY, S_LP, 0, 3'b100, "R5 core uv standby");
    cyc(1, M_SBY, S_LP, 0, 3'b100, "R6 core flag held");
    uv_clr = 3'b100;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R6 pins decide after clear");
    uv_set = 3'b010;
    cyc(1, M_SLP, S_LP, 0, 3'b010, "R4 io uv sleep R12");
    uv_set = 3'b010; uv_clr = 3'b010;
    cyc(1, M_SLP, S_LP, 0, 3'b010, "R6 set beats clear");
    uv_clr = 3'b010;
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R6 io cleared");
    uv_set = 3'b001;
    cyc(1, M_SLP, S_LP, 0, 3'b001, "R4 battery uv sleep");
    uv_set = 3'b100;
    cyc(1, M_SLP, S_LP, 0, 3'b101, "R5 core flag in sleep");
    uv_clr = 3'b001;
    cyc(1, M_SLP, S_LP, 0, 3'b100, "R5 core keeps sleep");
    uv_set = 3'b011; uv_clr = 3'b000;
    cyc(1, M_SLP, S_LP, 0, 3'b111, "R4 all flags");
    wake = 1;
    cyc(1, M_SBY, S_LP, 0, 3'd0, "R7 wake clears flags");
    cyc(1, M_NRM, S_ID, 0, 3'd0, "R6 pins after wake");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule